// File: doc/BRIEF.md
# Differential Write Bit-Flip Reducer

This block sits in front of a resistive memory array and lowers the number of cells programmed by each cache-line write. When a write request arrives, it first fetches the line as it is currently stored. It then compares the new data with the old contents word by word. For each word it keeps either the plain data or its bitwise complement, whichever differs from the stored cells in fewer positions. A per-word flag bit records the choice and is counted as a cell. The encoded line is then sent to the array one group of words per cycle. Each group carries a per-bit write enable that is set only on cells whose value changes. Groups with nothing to change are skipped and take no cycle.

A read request fetches the stored line and undoes the inversion of every word whose flag is set, so the requester always sees true data. At the end of every write, the block reports how many cells it programmed.

In the array, each word takes a slot one bit wider than the data word. The line is split into groups, and each group is a whole number of slots.

Top module: `dw_flip_writer`

## Requirements
- R1: While reset is held and in the cycle it is released, req_ready is 1, and arr_rd_en, arr_wr_en, rsp_valid and wr_done are all 0.
- R2: For an accepted request, arr_rd_en is 1 for exactly one cycle, the cycle right after acceptance, with arr_rd_addr equal to the request address. No write cycle of that request comes before this read. The array returns arr_rd_data in the cycle after arr_rd_en.
- R3: Word k of the line uses slot k of the stored line: bits [k*(WORD_W+1) +: WORD_W+1]. The slot MSB is the flag, and the low WORD_W bits hold the data, stored inverted when the flag is 1. Group g covers stored bits [g*G +: G], where G = (GROUP_W/WORD_W)*(WORD_W+1), and arr_wr_grp carries g.
- R4: For each word, the stored slot after a write is {0,data} or {1,~data}, whichever has fewer bit differences from the old slot with the flag included.
- R5: When both forms give the same difference count, the new slot keeps the old flag value.
- R6: During a write cycle, arr_wr_mask is 1 exactly on the bits of the group where the new slot differs from the old one. arr_wr_data equals the new slot contents on every masked bit.
- R7: Each group with at least one masked bit is written exactly once, in ascending group order, on back-to-back cycles. The first write comes two cycles after the read. Groups with no masked bit are never presented, and a write with no changed bit issues no write cycle.
- R8: wr_done is a one-cycle pulse in the cycle after the last write cycle, or two cycles after the read when no group changes. In that cycle wr_bits equals the total number of masked bits of the request, which is never more than floor((WORD_W+1)/2) per word.
- R9: For a read request, rsp_valid is a one-cycle pulse two cycles after acceptance. rsp_rdata holds every word's stored data XOR its flag repeated across the word.
- R10: While a request is in progress, req_ready is 0 and req_valid is ignored. No other line is read or written because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | LINE_W | True data of the line to write |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | LINE_W | Decoded true line data |
| wr_done | output | 1 | Write request finished pulse |
| wr_bits | output | clog2(STORED+1) | Cells programmed by the finished write |
| arr_rd_en | output | 1 | Array line read enable |
| arr_rd_addr | output | ADDR_W | Array read address |
| arr_rd_data | input | STORED | Stored line, valid the cycle after arr_rd_en |
| arr_wr_en | output | 1 | Array group write enable |
| arr_wr_addr | output | ADDR_W | Array write address |
| arr_wr_grp | output | clog2(LINE_W/GROUP_W) | Group index within the line |
| arr_wr_data | output | G | Encoded group contents |
| arr_wr_mask | output | G | Per-bit program enable |

STORED is (LINE_W/WORD_W)*(WORD_W+1).

## Verification
The bench builds the block with WORD_W=15, LINE_W=120 and GROUP_W=30. This gives 16-bit slots, eight words and four groups of two words.

With an even slot width, a word with eight set data bits ties between its plain and inverted forms, so the flag-keeping rule can be reached. The default 33-bit slot can never tie.

Four groups are few enough that random per-word keep, invert and replace choices often leave some groups clean and others dirty. This exercises skipping, back-to-back writes and the no-write completion path.

// File: rtl/dw_flip_pkg.sv
package dw_flip_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ENCODE,
    ST_PROGRAM,
    ST_FINISH,
    ST_REPLY
  } dw_state_e;
endpackage

// File: rtl/dw_word_encode.sv
module dw_word_encode #(
  parameter int WORD_W = 32,
  localparam int SLOT_W = WORD_W + 1,
  localparam int FLIP_W = $clog2(SLOT_W + 1)
) (
  input  logic [SLOT_W-1:0] old_slot,
  input  logic [WORD_W-1:0] new_word,
  output logic [SLOT_W-1:0] new_slot,
  output logic [SLOT_W-1:0] flip_mask,
  output logic [FLIP_W-1:0] nflips
);
  function automatic logic [FLIP_W-1:0] ones(input logic [SLOT_W-1:0] v);
    logic [FLIP_W-1:0] c;
    c = '0;
    for (int i = 0; i < SLOT_W; i++) c = c + FLIP_W'(v[i]);
    return c;
  endfunction

  logic [SLOT_W-1:0] plain_form, inv_form;
  logic [FLIP_W-1:0] cost_plain, cost_inv;
  logic              use_inv;

  always_comb begin
    plain_form = {1'b0, new_word};
    inv_form   = {1'b1, ~new_word};
    cost_plain = ones(plain_form ^ old_slot);
    cost_inv   = ones(inv_form ^ old_slot);
    // tie keeps the stored flag so the flag cell is not cycled
    use_inv    = (cost_inv < cost_plain) ||
                 ((cost_inv == cost_plain) && old_slot[SLOT_W-1]);
    new_slot   = use_inv ? inv_form : plain_form;
    flip_mask  = new_slot ^ old_slot;
    nflips     = use_inv ? cost_inv : cost_plain;
  end
endmodule

// File: rtl/dw_line_decode.sv
module dw_line_decode #(
  parameter int WORD_W = 32,
  parameter int LINE_W = 512,
  localparam int SLOT_W = WORD_W + 1,
  localparam int NWORDS = LINE_W / WORD_W,
  localparam int STORED_W = NWORDS * SLOT_W
) (
  input  logic [STORED_W-1:0] stored,
  output logic [LINE_W-1:0]   truth
);
  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    logic [SLOT_W-1:0] slot;
    assign slot = stored[k*SLOT_W +: SLOT_W];
    assign truth[k*WORD_W +: WORD_W] = slot[WORD_W-1:0] ^ {WORD_W{slot[SLOT_W-1]}};
  end
endmodule

// File: rtl/dw_group_sched.sv
module dw_group_sched #(
  parameter int NGRP = 8,
  localparam int GIDX_W = $clog2(NGRP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NGRP-1:0]   load_vec,
  input  logic              advance,
  output logic              pick_valid,
  output logic [GIDX_W-1:0] pick_idx,
  output logic              pick_last
);
  logic [NGRP-1:0] pend_q, pick_oh;

  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (pend_q[g]) begin
        pick_oh    = '0;
        pick_oh[g] = 1'b1;
        pick_idx   = GIDX_W'(g);
      end
    end
    pick_valid = |pend_q;
    pick_last  = (pend_q & ~pick_oh) == '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (load)    pend_q <= load_vec;
    else if (advance) pend_q <= pend_q & ~pick_oh;
  end

  // R7: a write cycle is only requested while a dirty group is pending
  a_r7_advance_has_work: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> pick_valid);
  // R7: each write cycle retires exactly one pending group
  a_r7_pending_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> ($countones(pend_q) + 1 == $past($countones(pend_q))));
endmodule

// File: rtl/dw_flip_writer.sv
module dw_flip_writer
  import dw_flip_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int LINE_W  = 512,
  parameter int GROUP_W = 64,
  parameter int ADDR_W  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  input  logic req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LINE_W-1:0] req_wdata,
  output logic rsp_valid,
  output logic [LINE_W-1:0] rsp_rdata,
  output logic wr_done,
  output logic [$clog2((LINE_W/WORD_W)*(WORD_W+1)+1)-1:0] wr_bits,
  output logic arr_rd_en,
  output logic [ADDR_W-1:0] arr_rd_addr,
  input  logic [(LINE_W/WORD_W)*(WORD_W+1)-1:0] arr_rd_data,
  output logic arr_wr_en,
  output logic [ADDR_W-1:0] arr_wr_addr,
  output logic [$clog2(LINE_W/GROUP_W)-1:0] arr_wr_grp,
  output logic [(GROUP_W/WORD_W)*(WORD_W+1)-1:0] arr_wr_data,
  output logic [(GROUP_W/WORD_W)*(WORD_W+1)-1:0] arr_wr_mask
);
  localparam int SLOT_W   = WORD_W + 1;
  localparam int NWORDS   = LINE_W / WORD_W;
  localparam int STORED_W = NWORDS * SLOT_W;
  localparam int WPG      = GROUP_W / WORD_W;
  localparam int NGRP     = NWORDS / WPG;
  localparam int GSLOT_W  = WPG * SLOT_W;
  localparam int GIDX_W   = $clog2(NGRP);
  localparam int CNT_W    = $clog2(STORED_W + 1);
  localparam int FLIP_W   = $clog2(SLOT_W + 1);
  localparam int MAX_BITS = NWORDS * (SLOT_W / 2);

  dw_state_e          state;
  logic               is_wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [LINE_W-1:0]  wdata_q;
  logic [STORED_W-1:0] new_line_q, mask_q;
  logic [CNT_W-1:0]   bits_q;

  logic [STORED_W-1:0] enc_line, enc_mask;
  logic [FLIP_W-1:0]   word_flips [NWORDS];
  logic [CNT_W-1:0]    enc_bits;
  logic [NGRP-1:0]     grp_dirty;

  logic               pick_valid, pick_last;
  logic [GIDX_W-1:0]  pick_idx;

  // per-word encoders, fed by the fetched line
  for (genvar k = 0; k < NWORDS; k++) begin : g_enc
    dw_word_encode #(.WORD_W(WORD_W)) enc_i (
      .old_slot (arr_rd_data[k*SLOT_W +: SLOT_W]),
      .new_word (wdata_q[k*WORD_W +: WORD_W]),
      .new_slot (enc_line[k*SLOT_W +: SLOT_W]),
      .flip_mask(enc_mask[k*SLOT_W +: SLOT_W]),
      .nflips   (word_flips[k])
    );
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_dirty
    assign grp_dirty[g] = |enc_mask[g*GSLOT_W +: GSLOT_W];
  end

  always_comb begin
    enc_bits = '0;
    for (int k = 0; k < NWORDS; k++) enc_bits = enc_bits + CNT_W'(word_flips[k]);
  end

  dw_group_sched #(.NGRP(NGRP)) sched_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (state == ST_ENCODE),
    .load_vec  (grp_dirty),
    .advance   (state == ST_PROGRAM),
    .pick_valid(pick_valid),
    .pick_idx  (pick_idx),
    .pick_last (pick_last)
  );

  dw_line_decode #(.WORD_W(WORD_W), .LINE_W(LINE_W)) dec_i (
    .stored(arr_rd_data),
    .truth (rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      is_wr_q    <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      new_line_q <= '0;
      mask_q     <= '0;
      bits_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          is_wr_q <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          state   <= ST_FETCH;
        end
        ST_FETCH: state <= is_wr_q ? ST_ENCODE : ST_REPLY;
        ST_ENCODE: begin
          new_line_q <= enc_line;
          mask_q     <= enc_mask;
          bits_q     <= enc_bits;
          state      <= (|grp_dirty) ? ST_PROGRAM : ST_FINISH;
        end
        ST_PROGRAM: if (pick_last) state <= ST_FINISH;
        ST_FINISH:  state <= ST_IDLE;
        ST_REPLY:   state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign arr_rd_en   = (state == ST_FETCH);
  assign arr_rd_addr = addr_q;
  assign arr_wr_en   = (state == ST_PROGRAM);
  assign arr_wr_addr = addr_q;
  assign arr_wr_grp  = pick_idx;
  assign arr_wr_data = new_line_q[pick_idx*GSLOT_W +: GSLOT_W];
  assign arr_wr_mask = mask_q[pick_idx*GSLOT_W +: GSLOT_W];
  assign wr_done     = (state == ST_FINISH);
  assign wr_bits     = bits_q;
  assign rsp_valid   = (state == ST_REPLY);

  // R1: the block comes out of reset idle and ready
  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_ready && !arr_rd_en && !arr_wr_en && !rsp_valid && !wr_done));
  // R2: one read per request
  a_r2_single_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en |=> !arr_rd_en);
  // R10: acceptance leads to the fetch and closes the request port
  a_r10_accept_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (arr_rd_en && !req_ready));
  // R7: a presented group always carries at least one enabled cell
  a_r7_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |-> (|arr_wr_mask));
  // R7: consecutive write cycles move to a higher group
  a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_en && $past(arr_wr_en)) |-> (arr_wr_grp > $past(arr_wr_grp)));
  // R8: completion is a single pulse with a bounded count
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);
  a_r8_bits_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (int'(wr_bits) <= MAX_BITS));
  // R9: read response is a single pulse
  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/dw_flip_writer_tb.sv
`timescale 1ns/1ps
module dw_flip_writer_tb_top;
  localparam int WORD_W = 15, LINE_W = 120, GROUP_W = 30, ADDR_W = 3;
  localparam int SLOT_W = WORD_W + 1;
  localparam int NW = LINE_W / WORD_W;
  localparam int STW = NW * SLOT_W;
  localparam int WPG = GROUP_W / WORD_W;
  localparam int NG = NW / WPG;
  localparam int GS = WPG * SLOT_W;
  localparam int GIW = $clog2(NG);
  localparam int CW = $clog2(STW + 1);
  localparam int NLINES = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LINE_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, wr_done, arr_rd_en, arr_wr_en;
  logic [LINE_W-1:0] rsp_rdata;
  logic [CW-1:0] wr_bits;
  logic [ADDR_W-1:0] arr_rd_addr, arr_wr_addr;
  logic [STW-1:0] arr_rd_data;
  logic [GIW-1:0] arr_wr_grp;
  logic [GS-1:0] arr_wr_data, arr_wr_mask;

  dw_flip_writer #(.WORD_W(WORD_W), .LINE_W(LINE_W), .GROUP_W(GROUP_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_done(wr_done), .wr_bits(wr_bits),
    .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data),
    .arr_wr_en(arr_wr_en), .arr_wr_addr(arr_wr_addr), .arr_wr_grp(arr_wr_grp),
    .arr_wr_data(arr_wr_data), .arr_wr_mask(arr_wr_mask));

  // array model with a preload path
  logic [STW-1:0] mem [NLINES];
  logic pre_en = 1'b0;
  logic [ADDR_W-1:0] pre_addr = '0;
  logic [STW-1:0] pre_data = '0;
  always @(posedge clk) begin
    if (pre_en) mem[pre_addr] <= pre_data;
    else begin
      if (arr_rd_en) arr_rd_data <= mem[arr_rd_addr];
      if (arr_wr_en)
        mem[arr_wr_addr][arr_wr_grp*GS +: GS] <=
          (mem[arr_wr_addr][arr_wr_grp*GS +: GS] & ~arr_wr_mask) | (arr_wr_data & arr_wr_mask);
    end
  end

  logic [STW-1:0] img [NLINES];
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [STW-1:0] act, input logic [STW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [SLOT_W-1:0] ref_slot(input logic [SLOT_W-1:0] old, input logic [WORD_W-1:0] d);
    int pd = 0;
    for (int i = 0; i < WORD_W; i++) if (d[i] != old[i]) pd++;
    if (old[SLOT_W-1]) pd++;
    if (SLOT_W - pd < pd) return {1'b1, ~d};
    if (SLOT_W - pd == pd) return old[SLOT_W-1] ? {1'b1, ~d} : {1'b0, d};
    return {1'b0, d};
  endfunction

  function automatic logic [LINE_W-1:0] ref_true(input logic [STW-1:0] s);
    logic [LINE_W-1:0] t;
    for (int k = 0; k < NW; k++)
      for (int i = 0; i < WORD_W; i++)
        t[k*WORD_W+i] = s[k*SLOT_W+i] ^ s[k*SLOT_W+WORD_W];
    return t;
  endfunction

  function automatic logic [LINE_W-1:0] rnd_line();
    logic [LINE_W-1:0] v;
    for (int i = 0; i < LINE_W; i++) v[i] = $urandom_range(0, 1) == 1;
    return v;
  endfunction

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] d, input bit spam);
    logic [STW-1:0] nimg, nmask, other;
    int exp_bits = 0, k = 0, widx = 0, n = 1;
    int dirty [NG];
    bit done_seen = 0;
    for (int w = 0; w < NW; w++)
      nimg[w*SLOT_W +: SLOT_W] = ref_slot(img[a][w*SLOT_W +: SLOT_W], d[w*WORD_W +: WORD_W]);
    nmask = nimg ^ img[a];
    for (int i = 0; i < STW; i++) if (nmask[i]) exp_bits++;
    for (int g = 0; g < NG; g++) if (nmask[g*GS +: GS] != '0) begin dirty[k] = g; k++; end
    other = img[a + 1'b1];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (spam) begin req_addr = a + 1'b1; req_wdata = ~d; req_write = 1; end
    else req_valid = 0;
    chk(arr_rd_en && arr_rd_addr == a && !arr_wr_en, "R2 fetch after accept", STW'(arr_rd_addr), STW'(a));
    while (n < 3 + NG + 2 && !done_seen) begin
      @(negedge clk); n++;
      if (spam) chk(!req_ready, "R10 busy not ready", STW'(req_ready), '0);
      if (arr_wr_en) begin
        chk(widx < k && int'(arr_wr_grp) == dirty[widx] && n == 3 + widx, "R7 group order",
            STW'(arr_wr_grp), STW'(widx < k ? dirty[widx] : -1));
        chk(arr_wr_mask == nmask[arr_wr_grp*GS +: GS], "R6 write mask", STW'(arr_wr_mask), STW'(nmask[arr_wr_grp*GS +: GS]));
        chk((arr_wr_data & arr_wr_mask) == (nimg[arr_wr_grp*GS +: GS] & arr_wr_mask), "R6 write data",
            STW'(arr_wr_data), STW'(nimg[arr_wr_grp*GS +: GS]));
        widx++;
      end
      if (wr_done) begin
        done_seen = 1;
        req_valid = 0;
        chk(n == 3 + k && widx == k, "R8 done timing", STW'(n), STW'(3 + k));
        chk(int'(wr_bits) == exp_bits, "R8 programmed bits", STW'(wr_bits), STW'(exp_bits));
      end
    end
    req_valid = 0;
    chk(done_seen, "R8 done seen", STW'(done_seen), STW'(1));
    @(negedge clk);
    chk(!wr_done, "R8 done pulse", STW'(wr_done), '0);
    chk(mem[a] == nimg, "R4 stored encoding", mem[a], nimg);
    if (spam) chk(mem[a + 1'b1] == other, "R10 other line untouched", mem[a + 1'b1], other);
    img[a] = nimg;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a);
    logic [LINE_W-1:0] exp;
    exp = ref_true(img[a]);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(arr_rd_en && arr_rd_addr == a, "R2 read fetch", STW'(arr_rd_addr), STW'(a));
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == exp, "R9 decoded data", STW'(rsp_rdata), STW'(exp));
    @(negedge clk);
    chk(!rsp_valid, "R9 single pulse", STW'(rsp_valid), '0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired act=hang exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [LINE_W-1:0] d, t;
    void'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    chk(req_ready && !arr_rd_en && !arr_wr_en && !rsp_valid && !wr_done, "R1 in reset", STW'(req_ready), STW'(1));
    // preload random stored lines (random flags)
    for (int i = 0; i < NLINES; i++) begin
      logic [STW-1:0] v;
      for (int b = 0; b < STW; b++) v[b] = $urandom_range(0, 1) == 1;
      pre_en = 1; pre_addr = ADDR_W'(i); pre_data = v; img[i] = v;
      @(negedge clk);
    end
    pre_en = 0;
    rst_n = 1;
    #0;
    chk(req_ready && !arr_wr_en && !wr_done, "R1 after release", STW'(req_ready), STW'(1));
    // R9/R3 decode of preloaded flags
    do_read(0);
    do_read(5);
    // R7 unchanged data: no write cycle at all
    do_write(1, ref_true(img[1]), 0);
    // R4 full inversion flips only flags
    do_write(1, ~ref_true(img[1]), 0);
    // R5 tie words: 8 of 15 data bits set against a zero word
    do_write(2, '0, 0);
    d = '0;
    for (int w = 0; w < NW; w++) d[w*WORD_W +: WORD_W] = (w % 2 == 0) ? 15'h00FF : 15'h7F80;
    do_write(2, d, 0);
    chk(mem[2][SLOT_W-1] == img[2][SLOT_W-1], "R5 tie keeps flag", STW'(mem[2][SLOT_W-1]), STW'(img[2][SLOT_W-1]));
    do_read(2);
    // R7 single word change touches one group
    t = ref_true(img[3]);
    t[5*WORD_W] = ~t[5*WORD_W];
    do_write(3, t, 0);
    // R10 request held high while busy
    do_write(4, rnd_line(), 1);
    do_read(4);
    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'($urandom_range(0, NLINES - 1));
      t = ref_true(img[a]);
      d = rnd_line();
      for (int w = 0; w < NW; w++) begin
        int c = $urandom_range(0, 3);
        if (c == 0) d[w*WORD_W +: WORD_W] = t[w*WORD_W +: WORD_W];
        else if (c == 1) d[w*WORD_W +: WORD_W] = ~t[w*WORD_W +: WORD_W];
      end
      do_write(a, d, it % 7 == 0);
      if (it % 3 == 0) do_read(a);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule